// File: doc/BRIEF.md
# PC-Relative Branch Target Unit

This block sits in the execute stage of a processor pipeline and resolves relative jumps. Each cycle it looks at one 32-bit instruction word, the program counter of that instruction, and a single pass/fail flag from the external condition logic. When the word carries the branch tag and the condition passes, the block computes a jump destination. It takes the 24-bit signed word offset, scales it to bytes and adds it to the pipeline-adjusted PC, which is the instruction's own address plus 8. In every other case it hands back the next sequential address.

A second flag in the same encoding turns the jump into a call. The block then also raises a write request for the link register and supplies the return address, which is the address of the instruction after the call. Every result is registered and appears one clock after the inputs are sampled. The taken and link-write outputs act as single-cycle strobes.

Top module: `bt_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output (`next_pc`, `taken`, `link_we`, `link_addr`) is zero after that edge, whatever the inputs are.
- R2: An instruction is a branch only when bits 27..25 equal 3'b101. Any other value in those bits gives `taken`=0, `link_we`=0 and `next_pc`=pc+4.
- R3: For a branch with `cond_ok`=1, `taken`=1 and `next_pc` = pc + 8 + (bits 23..0 sign-extended from bit 23, shifted left by two), computed modulo 2^32.
- R4: The offset extremes are handled with correct sign. An offset of 0x7FFFFF adds +0x1FFFFFC to pc+8, and an offset of 0x800000 adds -0x2000000, so reach is about ±32 MB.
- R5: For a taken branch with bit 24 = 1, `link_we`=1 and `link_addr`=pc+4.
- R6: For a taken branch with bit 24 = 0, `link_we`=0 and `link_addr`=0. `link_addr` is 0 whenever `link_we` is 0.
- R7: When `cond_ok`=0, even a branch with bit 24 = 1 gives `taken`=0, `link_we`=0 and `next_pc`=pc+4.
- R8: Bits 31..28 (the condition field) have no effect on any output. The condition is judged only through `cond_ok`.
- R9: Outputs reflect the inputs sampled at the previous rising edge. A change of inputs does not show on the outputs until the next edge, and back-to-back instructions each produce their own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word under execution |
| pc | input | 32 | Address of that instruction |
| cond_ok | input | 1 | External condition evaluation passed |
| next_pc | output | 32 | Registered next fetch address |
| taken | output | 1 | Registered strobe: a branch was taken |
| link_we | output | 1 | Registered strobe: write link register |
| link_addr | output | 32 | Registered return address, zero when not writing |

## Verification
The bench uses the largest positive and largest negative offsets. A design that extended the sign from the wrong bit, or forgot the two-bit scaling, would land megabytes away, or jump forward where it should go back. It also covers a target that wraps past the top of the address space, a call whose condition fails, and tag values next to 3'b101 (3'b100, 3'b111, 3'b001). A mis-decoded tag or a link strobe not gated by the condition would then show as a spurious jump or a corrupted link register. Changing only the condition field, and changing inputs just before an edge, catch a design that reads bits 31..28 or that leaks its result combinationally.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int OFF_W    = 24;
  localparam int LINK_BIT = 24;
  localparam int TAG_LO   = 25;
  localparam int TAG_HI   = 27;
  localparam int TAG_W    = TAG_HI - TAG_LO + 1;
  localparam logic [TAG_W-1:0] BR_TAG = 3'b101;

  typedef struct packed {
    logic             is_branch;
    logic             link;
    logic [OFF_W-1:0] off;
  } bt_fields_t;
endpackage

// File: rtl/bt_decode.sv
module bt_decode
  import bt_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  output bt_fields_t      fields
);
  // condition field is evaluated elsewhere; kept visibly unused here
  logic unused_cond;
  assign unused_cond = ^instr[XLEN-1:TAG_HI+1];

  always_comb begin
    fields.is_branch = (instr[TAG_HI:TAG_LO] == BR_TAG);
    fields.link      = instr[LINK_BIT];
    fields.off       = instr[OFF_W-1:0];
  end
endmodule

// File: rtl/bt_target.sv
module bt_target #(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 24,
  parameter int SHIFT    = 2,
  parameter int PIPE_ADJ = 8,
  parameter int STEP     = 4
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  seq
);
  localparam int DISP_W = OFF_W + SHIFT;
  localparam logic [XLEN-1:0] ADJ  = PIPE_ADJ;
  localparam logic [XLEN-1:0] STP  = STEP;

  logic [XLEN-1:0] disp;

  assign disp   = {{(XLEN-DISP_W){off[OFF_W-1]}}, off, {SHIFT{1'b0}}};
  assign target = pc + ADJ + disp;
  assign seq    = pc + STP;
endmodule

// File: rtl/bt_unit.sv
module bt_unit
  import bt_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int SHIFT    = 2,
  parameter int PIPE_ADJ = 8,
  parameter int STEP     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] pc,
  input  logic            cond_ok,
  output logic [XLEN-1:0] next_pc,
  output logic            taken,
  output logic            link_we,
  output logic [XLEN-1:0] link_addr
);
  bt_fields_t      f;
  logic [XLEN-1:0] tgt;
  logic [XLEN-1:0] seq;
  logic            go;
  logic            call;

  bt_decode #(.XLEN(XLEN)) u_dec (
    .instr  (instr),
    .fields (f)
  );

  bt_target #(
    .XLEN(XLEN), .OFF_W(OFF_W), .SHIFT(SHIFT),
    .PIPE_ADJ(PIPE_ADJ), .STEP(STEP)
  ) u_tgt (
    .pc     (pc),
    .off    (f.off),
    .target (tgt),
    .seq    (seq)
  );

  assign go   = f.is_branch & cond_ok;
  assign call = go & f.link;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc   <= '0;
      taken     <= 1'b0;
      link_we   <= 1'b0;
      link_addr <= '0;
    end else begin
      next_pc   <= go ? tgt : seq;
      taken     <= go;
      link_we   <= call;
      link_addr <= call ? seq : '0;
    end
  end
endmodule

// File: rtl/bt_unit_chk.sv
module bt_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] pc,
  input logic            cond_ok,
  input logic [XLEN-1:0] next_pc,
  input logic            taken,
  input logic            link_we,
  input logic [XLEN-1:0] link_addr
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (next_pc == '0) && !taken && !link_we && (link_addr == '0));

  p_nonbranch_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (instr[27:25] != 3'b101) |=> !taken && !link_we && (next_pc == $past(pc) + 32'd4));

  p_target_align_r3: assert property (@(posedge clk) disable iff (rst)
    (instr[27:25] == 3'b101 && cond_ok) |=> taken && (next_pc[1:0] == $past(pc[1:0])));

  p_link_value_r5: assert property (@(posedge clk) disable iff (rst)
    (instr[27:25] == 3'b101 && cond_ok && instr[24]) |=> link_we && (link_addr == $past(pc) + 32'd4));

  p_link_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !link_we |-> (link_addr == '0));

  p_link_needs_taken_r6: assert property (@(posedge clk) disable iff (rst)
    link_we |-> taken);

  p_condfail_r7: assert property (@(posedge clk) disable iff (rst)
    !cond_ok |=> !taken && !link_we && (next_pc == $past(pc) + 32'd4));
endmodule

bind bt_unit bt_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .instr(instr), .pc(pc), .cond_ok(cond_ok),
  .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_addr(link_addr)
);

// File: tb/bt_unit_tb.sv
module bt_unit_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic        cond_ok = 1'b0;
  logic [31:0] next_pc;
  logic        taken;
  logic        link_we;
  logic [31:0] link_addr;

  int total = 0;
  int bad   = 0;

  bt_unit u_dut (
    .clk(clk), .rst(rst), .instr(instr), .pc(pc), .cond_ok(cond_ok),
    .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_addr(link_addr)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [2:0] tag,
                                     input logic l, input logic [23:0] off);
    return {c, tag, l, off};
  endfunction

  function automatic logic [31:0] dest(input logic [31:0] p, input logic [23:0] off);
    return p + 32'd8 + {{6{off[23]}}, off, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample just after the next rising edge
  task automatic apply(input logic [31:0] i, input logic [31:0] p, input logic c);
    @(negedge clk);
    instr = i; pc = p; cond_ok = c;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_seq(input string req, input logic [31:0] p);
    chk({req, " next_pc"}, next_pc, p + 32'd4);
    chk({req, " taken"}, {31'd0, taken}, 32'd0);
    chk({req, " link_we"}, {31'd0, link_we}, 32'd0);
    chk({req, " link_addr"}, link_addr, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    instr = mk(4'he, 3'b101, 1'b1, 24'h000010); pc = 32'h100; cond_ok = 1'b1;
    @(posedge clk); #1;
    chk("R1 next_pc", next_pc, 32'd0);
    chk("R1 taken", {31'd0, taken}, 32'd0);
    chk("R1 link_we", {31'd0, link_we}, 32'd0);
    chk("R1 link_addr", link_addr, 32'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_forward;
    apply(mk(4'he, 3'b101, 1'b0, 24'h000010), 32'h0000_1000, 1'b1);
    chk("R3 fwd next_pc", next_pc, dest(32'h0000_1000, 24'h000010));
    chk("R3 fwd taken", {31'd0, taken}, 32'd1);
    chk("R6 nolink link_we", {31'd0, link_we}, 32'd0);
    chk("R6 nolink link_addr", link_addr, 32'd0);
  endtask

  task automatic t_backward;
    apply(mk(4'he, 3'b101, 1'b0, 24'hFFFFFE), 32'h0000_2000, 1'b1);
    chk("R3 back next_pc", next_pc, 32'h0000_2000);
    apply(mk(4'he, 3'b101, 1'b0, 24'hFFFFF0), 32'h0040_0000, 1'b1);
    chk("R3 back2 next_pc", next_pc, 32'h0040_0000 + 32'd8 - 32'd64);
  endtask

  task automatic t_extremes;
    apply(mk(4'he, 3'b101, 1'b0, 24'h7FFFFF), 32'h1000_0000, 1'b1);
    chk("R4 max next_pc", next_pc, 32'h1000_0008 + 32'h01FF_FFFC);
    apply(mk(4'he, 3'b101, 1'b0, 24'h800000), 32'h1000_0000, 1'b1);
    chk("R4 min next_pc", next_pc, 32'h1000_0008 - 32'h0200_0000);
  endtask

  task automatic t_wrap;
    apply(mk(4'he, 3'b101, 1'b0, 24'h000000), 32'hFFFF_FFF8, 1'b1);
    chk("R3 wrap next_pc", next_pc, 32'h0000_0000);
  endtask

  task automatic t_link;
    apply(mk(4'he, 3'b101, 1'b1, 24'h000100), 32'h0000_8000, 1'b1);
    chk("R5 call next_pc", next_pc, dest(32'h0000_8000, 24'h000100));
    chk("R5 call taken", {31'd0, taken}, 32'd1);
    chk("R5 call link_we", {31'd0, link_we}, 32'd1);
    chk("R5 call link_addr", link_addr, 32'h0000_8004);
  endtask

  task automatic t_condfail;
    apply(mk(4'h0, 3'b101, 1'b1, 24'h000100), 32'h0000_3000, 1'b0);
    expect_seq("R7 condfail", 32'h0000_3000);
  endtask

  task automatic t_nonbranch;
    apply(mk(4'he, 3'b100, 1'b1, 24'h000040), 32'h0000_0400, 1'b1);
    expect_seq("R2 tag100", 32'h0000_0400);
    apply(mk(4'he, 3'b111, 1'b1, 24'h000040), 32'h0000_0500, 1'b1);
    expect_seq("R2 tag111", 32'h0000_0500);
    apply(mk(4'he, 3'b001, 1'b1, 24'h000040), 32'h0000_0600, 1'b1);
    expect_seq("R2 tag001", 32'h0000_0600);
  endtask

  task automatic t_condfield;
    for (int c = 0; c < 16; c++) begin
      apply(mk(c[3:0], 3'b101, 1'b1, 24'h000020), 32'h0000_7000, 1'b1);
      chk("R8 cond field next_pc", next_pc, dest(32'h0000_7000, 24'h000020));
      chk("R8 cond field link_addr", link_addr, 32'h0000_7004);
    end
  endtask

  task automatic t_latency;
    apply(mk(4'he, 3'b101, 1'b1, 24'h000004), 32'h0000_9000, 1'b1);
    @(negedge clk);
    instr = mk(4'he, 3'b000, 1'b0, 24'h0); pc = 32'h0000_A000; cond_ok = 1'b1;
    #1;
    chk("R9 hold next_pc", next_pc, dest(32'h0000_9000, 24'h000004));
    chk("R9 hold link_we", {31'd0, link_we}, 32'd1);
    @(posedge clk); #1;
    expect_seq("R9 b2b", 32'h0000_A000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_forward();
        t_backward();
        t_extremes();
        t_wrap();
        t_link();
        t_condfail();
        t_nonbranch();
        t_condfield();
        t_latency();
      end
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule